// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a two-channel serial audio stream (bit clock, word select, serial data) and turns it into a pair of signed 24-bit parallel samples. It runs directly in the bit-clock domain as a slave: data and word select are sampled on the rising edge, and word select is expected to change only on falling edges. A two-bit select input picks one of four framings. In the first, the word starts one slot after each word-select change. In the other three, the word is right-aligned to the end of each half-frame, with a width of 16, 20 or 24 bits.

Once both channels of a frame are in hand, the pair is presented on the outputs with a one-cycle strobe. A mute input does not cut the output abruptly. Instead, it ramps a gain down to zero over a fixed number of frames, and it ramps the gain back up when mute is released. A change of the framing select is only picked up at the start of a left half-frame, so no sample is built from two framings.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and right after it, `frame_valid` is 0 and both sample outputs are 0.
- R2: With `fmt_sel` = 00 (start-anchored framing), the bit sampled in slot 1 of a half-frame is the sample MSB (bit 23). Slot 0 is the slot whose rising edge first sees the new `ws` level. Slots 1..24 fill bits 23..0. Slots after the 24th are ignored. If the half-frame ends before slot 24, the missing low bits are 0.
- R3: With `fmt_sel` = 01, 10 or 11, the last 16, 20 or 24 slots before a `ws` change carry the word MSB first, ending with the LSB. The word is sign-extended to 24 bits. Bits that arrive earlier in the half-frame are discarded.
- R4: The half-frame with `ws` low gives the left sample. The half-frame with `ws` high gives the right sample.
- R5: `frame_valid` is high for exactly one cycle. That cycle follows the rising edge that samples the first slot of a left half-frame, and only when a complete left and right half-frame precede that edge. After reset, the first left half-frame must itself start with a high-to-low `ws` change.
- R6: `fmt_sel` is sampled only on the rising edge that starts a left half-frame. A change at any other time has no effect on the frame in progress.
- R7: A gain level g in 0..2^GAIN_SHIFT (default 8) starts at full scale after reset. It steps by one on each strobe: down while `mute` is high, up while it is low. Each output equals floor(sample * g / 2^GAIN_SHIFT), so at full gain samples pass unchanged and at g = 0 they are 0.
- R8: Half-frames of any length from the word width up to 32 slots decode correctly in every framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock. All sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select: low for left, high for right |
| sdata | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Framing: 00 start-anchored, 01/10/11 end-anchored 16/20/24 bits |
| mute | input | 1 | Requests a soft ramp of the output gain to zero |
| left_out | output | 24 | Left sample, signed, after gain |
| right_out | output | 24 | Right sample, signed, after gain |
| frame_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
Every result lands one register after the rising edge that samples the first slot of the following left half-frame. The strobe, both samples, the gain step and the framing pick-up are all due in the cycle after that edge. The bench drives each slot on a falling edge and compares all outputs at the next falling edge. At that point any emission due from the previous slot is already settled, so the expected strobe is armed one slot ahead and checked on every cycle, including every cycle where it must stay low. Mute and framing changes are applied on the same falling edge as the left-start slot or in the middle of a half-frame. This gives a fixed, known cycle for each effect.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int GAIN_SHIFT = 3
) (
  input  logic               bclk,
  input  logic               rst_n,
  input  logic               ws,
  input  logic               sdata,
  input  logic [1:0]         fmt_sel,
  input  logic               mute,
  output logic signed [23:0] left_out,
  output logic signed [23:0] right_out,
  output logic               frame_valid
);

  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 5;
  localparam int GAIN_W   = GAIN_SHIFT + 1;
  localparam int GAIN_MAX = 1 << GAIN_SHIFT;
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

  logic                ws_q, started;
  logic [SLOT_W-1:0]   cnt;
  logic [1:0]          fmt_act;
  logic [SAMPLE_W-1:0] shreg, i2s_w;
  logic signed [SAMPLE_W-1:0] left_hold;
  logic [GAIN_W-1:0]   gain, gain_nx;

  wire               ws_edge    = ws ^ ws_q;
  wire               left_start = ws_edge & ~ws;
  wire [SLOT_W-1:0]  slot       = ws_edge ? '0 : ((cnt == SLOT_LAST) ? cnt : cnt + 1'b1);
  wire [SLOT_W-1:0]  i2s_pos    = SLOT_W'(SAMPLE_W) - slot;
  wire               i2s_take   = (slot != '0) && (slot <= SLOT_W'(SAMPLE_W));

  function automatic logic signed [SAMPLE_W-1:0] right_aligned(input logic [SAMPLE_W-1:0] s,
                                                             input logic [1:0] f);
    case (f)
      2'b01:   return SAMPLE_W'(signed'(s[15:0]));
      2'b10:   return SAMPLE_W'(signed'(s[19:0]));
      default: return signed'(s);
    endcase
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] scaled(input logic signed [SAMPLE_W-1:0] w,
                                                      input logic [GAIN_W-1:0] g);
    logic signed [SAMPLE_W+GAIN_W:0] p;
    p = w * $signed({1'b0, g});
    return SAMPLE_W'(p >>> GAIN_SHIFT);
  endfunction

  // word of the half-frame that ends at this edge
  wire signed [SAMPLE_W-1:0] word_now = (fmt_act == 2'b00) ? signed'(i2s_w)
                                                          : right_aligned(shreg, fmt_act);

  always_comb begin
    gain_nx = gain;
    if (mute && gain != '0)
      gain_nx = gain - 1'b1;
    else if (!mute && gain != GAIN_W'(GAIN_MAX))
      gain_nx = gain + 1'b1;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q        <= 1'b0;
      started     <= 1'b0;
      cnt         <= '0;
      fmt_act     <= 2'b00;
      shreg       <= '0;
      i2s_w       <= '0;
      left_hold   <= '0;
      gain        <= GAIN_W'(GAIN_MAX);
      left_out    <= '0;
      right_out   <= '0;
      frame_valid <= 1'b0;
    end else begin
      ws_q        <= ws;
      cnt         <= slot;
      frame_valid <= 1'b0;
      shreg       <= {shreg[SAMPLE_W-2:0], sdata};
      if (ws_edge)
        i2s_w <= '0;
      else if (i2s_take)
        i2s_w[i2s_pos] <= sdata;
      // R4: ws low half-frame is the left channel
      if (ws_edge && ws)
        left_hold <= word_now;
      if (left_start) begin
        fmt_act <= fmt_sel;
        started <= 1'b1;
        if (started) begin
          left_out    <= scaled(left_hold, gain_nx);
          right_out   <= scaled(word_now, gain_nx);
          gain        <= gain_nx;
          frame_valid <= 1'b1;
        end
      end
    end
  end

  p_valid_single_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_valid_at_left_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |-> (!$past(ws) && $past(ws_q)));

  p_fmt_at_left_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(fmt_act) |-> ($past(ws_q) && !$past(ws)));

  p_gain_step_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(gain) |-> (frame_valid &&
      ((gain == $past(gain) + 1'b1) || (gain + 1'b1 == $past(gain)))));

  p_silent_at_zero_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_valid && gain == '0) |-> (left_out == '0 && right_out == '0));

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        mute = 1'b0;
  logic signed [23:0] left_out, right_out;
  logic        frame_valid;

  serial_audio_rx dut (
    .bclk(clk), .rst_n(rst_n), .ws(ws), .sdata(sdata), .fmt_sel(fmt_sel),
    .mute(mute), .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  always #2 clk = ~clk;

  int vec = 0, bad = 0, cycles = 0, g = 8;
  bit done = 0;
  bit exp_valid = 0, pend = 0, have_left = 0;
  logic signed [23:0] exp_l = '0, exp_r = '0, pend_l = '0, pend_r = '0;
  string exp_tag = "R5", pend_tag = "R2";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected end before 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic tick_check();
    @(negedge clk);
    vec++;
    if (frame_valid !== exp_valid) begin
      bad++;
      $display("FAIL R5 strobe got %b expected %b", frame_valid, exp_valid);
    end
    if (exp_valid) begin
      // R4: left output must carry the ws-low word, right the ws-high word
      vec++;
      if (left_out !== exp_l) begin
        bad++;
        $display("FAIL %s left got %h expected %h", exp_tag, left_out, exp_l);
      end
      vec++;
      if (right_out !== exp_r) begin
        bad++;
        $display("FAIL %s right got %h expected %h", exp_tag, right_out, exp_r);
      end
    end
    exp_valid = 0;
  endtask

  task automatic drive_half(input bit w, input int nslots, input int f,
                            input logic [23:0] word, input int late, input bit m);
    logic signed [23:0] dec;
    int n;
    bit b;
    n = (f == 1) ? 16 : (f == 2) ? 20 : 24;
    for (int k = 0; k < nslots; k++) begin
      tick_check();
      if (k == 0 && !w) begin
        fmt_sel = 2'(f);
        mute = m;
        if (pend) begin
          if (m && g > 0) g--;
          else if (!m && g < 8) g++;
          exp_l = 24'((int'(pend_l) * g) >>> 3);
          exp_r = 24'((int'(pend_r) * g) >>> 3);
          exp_tag = (g != 8 || m) ? "R7" : pend_tag;
          exp_valid = 1;
          pend = 0;
        end
      end
      if (late >= 0 && k == 5) fmt_sel = 2'(late);
      if (f == 0) b = (k >= 1 && k <= 24) ? word[24-k] : 1'($urandom);
      else        b = (k >= nslots - n) ? word[nslots-1-k] : 1'($urandom);
      ws = w;
      sdata = b;
    end
    dec = word;
    if (f == 0) begin
      for (int i = 0; i < 24 - (nslots - 1); i++) dec[i] = 1'b0;
    end else begin
      for (int i = n; i < 24; i++) dec[i] = word[n-1];
    end
    if (!w) begin
      pend_l = dec;
      have_left = 1;
      if (late >= 0)        pend_tag = "R6";
      else if (nslots < 32) pend_tag = "R8";
      else                  pend_tag = (f == 0) ? "R2" : "R3";
    end else begin
      pend_r = dec;
      pend = have_left;
      have_left = 0;
    end
  endtask

  task automatic frame(input int f, input int nslots, input logic [23:0] lw,
                       input logic [23:0] rw, input int late, input bit m);
    drive_half(0, nslots, f, lw, late, m);
    drive_half(1, nslots, f, rw, -1, m);
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      vec++;
      if (frame_valid !== 1'b0 || left_out !== 24'd0 || right_out !== 24'd0) begin
        bad++;
        $display("FAIL R1 reset outputs got %b/%h/%h expected 0/000000/000000",
                 frame_valid, left_out, right_out);
      end
    end
    rst_n = 1'b1;
    drive_half(1, 32, 0, 24'h0, -1, 0);
    // R2: start-anchored framing, full and short half-frames
    frame(0, 32, 24'h123456, 24'hABCDEF, -1, 0);
    frame(0, 32, 24'h800001, 24'h7FFFFE, -1, 0);
    frame(0, 17, 24'hBEEF00, 24'h5A5A00, -1, 0);
    frame(0, 25, 24'h0F0F0F, 24'hF0F0F0, -1, 0);
    // R3: end-anchored framings, R8: shorter half-frames
    frame(1, 32, 24'h00_8123, 24'h00_7ABC, -1, 0);
    frame(1, 16, 24'h00_FFFF, 24'h00_0001, -1, 0);
    frame(2, 32, 24'h0_8_0000, 24'h0_7_FFFF, -1, 0);
    frame(2, 24, 24'h0_C_1234, 24'h0_3_4321, -1, 0);
    frame(3, 32, 24'h876543, 24'h345678, -1, 0);
    frame(3, 24, 24'hFFFFFF, 24'h000000, -1, 0);
    // R6: select change in mid left half-frame ignored until next left start
    frame(2, 32, 24'h0_9_ABCD, 24'h0_1_2345, 0, 0);
    frame(0, 32, 24'hC0FFEE, 24'h0BADF0, -1, 0);
    frame(3, 32, 24'h400000, 24'hC00000, 1, 0);
    frame(1, 32, 24'h00_4000, 24'h00_C000, -1, 0);
    // R7: soft mute ramp down then up
    for (int i = 0; i < 10; i++) frame(3, 32, 24'h7FFFFF - 24'(i), 24'h800000 + 24'(i * 3), -1, 1);
    for (int i = 0; i < 10; i++) frame(3, 32, 24'h654321 + 24'(i), 24'hA98765 - 24'(i), -1, 0);
    drive_half(0, 4, 3, 24'h0, -1, 0);
    repeat (3) tick_check();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule